// File: doc/BRIEF.md
# Partitioned SIMD Lane Replicator

This block doubles a packed SIMD word in a way that respects how the word is divided into elements. The input is a 16-bit word made of four 4-bit lanes. A 3-bit partition mask joins neighbouring lanes into elements. The block produces a 32-bit result in which every element appears twice in a row, inside its own region of the output. The word is not copied as a single value.

For each element, from the lowest to the highest, the output carries that element's lanes in ascending order and then the same lanes a second time. The result is packed from bit 0 upward. The block is combinational. An optional output register captures the result on each valid input and delays the valid flag by one clock.

Top module: `simd_repl`

## Requirements
- R1: Lane i of the input occupies bits 4i+3 down to 4i, so lane 0 holds the least significant nibble.
- R2: Mask bit i stands for the boundary between lane i and lane i+1. A one in that bit starts a new element at lane i+1, and a zero merges the two lanes into one element.
- R3: The output is filled from bit 0 upward in 4-bit steps. Each element, taken from the lowest lane upward, places its lanes in ascending order and then repeats them once in the same order, so the whole result is 32 bits with no gaps.
- R4: With mask 3'b000 the result is the input word in bits 15:0 and the same word again in bits 31:16.
- R5: With mask 3'b111 the result holds each lane twice in a row, so output nibbles 2i and 2i+1 both equal input lane i.
- R6: With mask 3'b010 the result is, from least to most significant, the low byte, the low byte, the high byte and the high byte.
- R7: With the output register enabled (the default), the result for an input accepted with in_valid high appears on the first rising edge after it, and out_valid equals in_valid delayed by one clock.
- R8: A cycle with in_valid low leaves out_result unchanged, whatever in_data and in_mask carry.
- R9: A synchronous active-high reset clears out_valid and out_result to zero on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_data and in_mask as a new operand |
| in_data | input | 16 | Four 4-bit lanes, with lane 0 in the least significant bits |
| in_mask | input | 3 | Partition mask. Bit i set splits lane i from lane i+1 |
| out_valid | output | 1 | in_valid delayed by one clock |
| out_result | output | 32 | Replicated, partition-aware result |

## Verification
Every result is due exactly one rising edge after the cycle in which in_valid was high. The valid flag follows on the same edge, and a reset takes effect on that edge as well. The bench drives inputs and compares outputs at the falling edge. Its behavioural reference model updates on the same rising edge as the design, so each comparison pairs the operand applied one clock earlier with the value the design should now show. Hold cycles and reset cycles are compared in the same way, with the model keeping or clearing its expected value.

// File: rtl/simd_repl_pkg.sv
package simd_repl_pkg;

  // width needed to hold the values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/simd_repl_groups.sv
module simd_repl_groups
  import simd_repl_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned IW = cnt_w(LANES)
) (
  input  logic [LANES-2:0]          mask,
  output logic [LANES-1:0][IW-1:0]  grp_start,
  output logic [LANES-1:0][IW-1:0]  grp_len
);

  for (genvar q = 0; q < LANES; q++) begin : g_lane
    logic [IW-1:0] st;
    logic [IW-1:0] en;

    // lowest lane of the element holding lane q
    always_comb begin
      st = '0;
      for (int b = 0; b < q; b++) begin
        if (mask[b]) st = IW'(b + 1);
      end
    end

    // highest lane of the element holding lane q
    always_comb begin
      en = IW'(LANES - 1);
      for (int b = LANES - 2; b >= q; b--) begin
        if (mask[b]) en = IW'(b);
      end
    end

    assign grp_start[q] = st;
    assign grp_len[q]   = IW'(en - st + 1'b1);
  end

endmodule

// File: rtl/simd_repl_route.sv
module simd_repl_route
  import simd_repl_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 4,
  localparam int unsigned IW    = cnt_w(LANES),
  localparam int unsigned IN_W  = LANES * LANE_W,
  localparam int unsigned SLOTS = 2 * LANES,
  localparam int unsigned OUT_W = SLOTS * LANE_W
) (
  input  logic [IN_W-1:0]           data,
  input  logic [LANES-1:0][IW-1:0]  grp_start,
  input  logic [LANES-1:0][IW-1:0]  grp_len,
  output logic [OUT_W-1:0]          result
);

  // Output slot s lies in the region of the element that holds lane s/2.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int unsigned Q = s / 2;
    int unsigned st;
    int unsigned ln;
    int unsigned k;
    int unsigned src;

    always_comb begin
      st  = int'(grp_start[Q]);
      ln  = int'(grp_len[Q]);
      k   = s - 2 * st;
      src = (k >= ln) ? (st + k - ln) : (st + k);
      if (src >= LANES) src = LANES - 1;
      result[s*LANE_W +: LANE_W] = data[src*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/simd_repl.sv
module simd_repl
  import simd_repl_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_W  = 4,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned IW     = cnt_w(LANES),
  localparam int unsigned IN_W   = LANES * LANE_W,
  localparam int unsigned OUT_W  = 2 * IN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [LANES-2:0] in_mask,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_result
);

  logic [LANES-1:0][IW-1:0] grp_start;
  logic [LANES-1:0][IW-1:0] grp_len;
  logic [OUT_W-1:0]         comb_res;

  simd_repl_groups #(.LANES(LANES)) u_groups (
    .mask      (in_mask),
    .grp_start (grp_start),
    .grp_len   (grp_len)
  );

  simd_repl_route #(.LANES(LANES), .LANE_W(LANE_W)) u_route (
    .data      (in_data),
    .grp_start (grp_start),
    .grp_len   (grp_len),
    .result    (comb_res)
  );

  if (REG_OUT) begin : g_reg
    logic             vld_q;
    logic [OUT_W-1:0] res_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) res_q <= comb_res;
      end
    end

    assign out_valid  = vld_q;
    assign out_result = res_q;

    // R7: valid is delayed by exactly one clock
    p_valid_delay_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    p_idle_delay_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    // R8: idle cycles keep the result
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_result));
    // R9: reset clears the outputs
    p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (!out_valid && out_result == '0));
    // R4: an unsplit word is copied twice
    p_whole_copy_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mask == '0) |=> out_result == {$past(in_data), $past(in_data)});
    // R5: fully split word gives each lane twice
    for (genvar q = 0; q < LANES; q++) begin : g_chk
      p_lane_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (&in_mask)) |=>
          (out_result[2*q*LANE_W +: LANE_W] == $past(in_data[q*LANE_W +: LANE_W]) &&
           out_result[(2*q+1)*LANE_W +: LANE_W] == $past(in_data[q*LANE_W +: LANE_W])));
    end
  end else begin : g_comb
    assign out_valid  = in_valid;
    assign out_result = comb_res;
  end

endmodule

// File: tb/simd_repl_test.sv
module simd_repl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [2:0]  in_mask = '0;
  logic        out_valid;
  logic [31:0] out_result;

  int checks = 0;
  int failures = 0;

  string cur_tag = "R9";
  string exp_tag = "R9";
  logic        exp_vld = 1'b0;
  logic [31:0] exp_res = '0;

  always #10 clk = ~clk;  // 50 MHz

  simd_repl uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_mask    (in_mask),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  // behavioural reference: mask -> run lengths -> emitted lanes (R1 R2 R3)
  function automatic logic [31:0] ref_repl(input logic [15:0] d, input logic [2:0] m);
    int runs[$];
    int n;
    int lane;
    int pos;
    logic [31:0] r;
    n = 1;
    r = '0;
    for (int i = 0; i < 3; i++) begin
      if (m[i]) begin
        runs.push_back(n);
        n = 1;
      end else begin
        n++;
      end
    end
    runs.push_back(n);
    lane = 0;
    pos = 0;
    foreach (runs[e]) begin
      for (int rep = 0; rep < 2; rep++) begin
        for (int k = 0; k < runs[e]; k++) begin
          r[pos*4 +: 4] = d[(lane+k)*4 +: 4];
          pos++;
        end
      end
      lane += runs[e];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    exp_tag <= cur_tag;
    if (rst) begin
      exp_vld <= 1'b0;
      exp_res <= '0;
    end else begin
      exp_vld <= in_valid;
      if (in_valid) exp_res <= ref_repl(in_data, in_mask);
    end
  end

  task automatic compare();
    checks++;
    if (out_valid !== exp_vld) begin
      failures++;
      $display("FAIL R7 out_valid actual=%0b expected=%0b", out_valid, exp_vld);
    end
    checks++;
    if (out_result !== exp_res) begin
      failures++;
      $display("FAIL %s out_result actual=0x%08h expected=0x%08h", exp_tag, out_result, exp_res);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [15:0] d,
                      input logic [2:0] m, input string tag);
    @(negedge clk);
    compare();
    rst = r;
    in_valid = v;
    in_data = d;
    in_mask = m;
    cur_tag = tag;
  endtask

  function automatic string tag_for(input logic [2:0] m);
    if (m == 3'b000) return "R4";
    if (m == 3'b111) return "R5";
    if (m == 3'b010) return "R6";
    return "R1 R2 R3";
  endfunction

  initial begin
    logic [15:0] pats[$];
    pats = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A};
    for (int i = 0; i < 4; i++) pats.push_back(16'($urandom()));

    // reset state, R9
    step(1'b1, 1'b0, 16'h1234, 3'b000, "R9");
    step(1'b1, 1'b1, 16'h1234, 3'b101, "R9");
    step(1'b0, 1'b0, 16'h0000, 3'b000, "R9");

    // every mask against every pattern, back to back
    for (int m = 0; m < 8; m++) begin
      foreach (pats[p]) step(1'b0, 1'b1, pats[p], 3'(m), tag_for(3'(m)));
    end

    // R8: idle cycles with changing inputs
    step(1'b0, 1'b1, 16'hDCBA, 3'b010, "R6");
    step(1'b0, 1'b0, 16'h1F1F, 3'b111, "R8");
    step(1'b0, 1'b0, 16'hF1F1, 3'b000, "R8");
    step(1'b0, 1'b0, 16'h0000, 3'b011, "R8");

    // R7: valid toggling
    for (int i = 0; i < 16; i++) begin
      logic [15:0] d;
      d = 16'($urandom());
      step(1'b0, 1'(i % 3 != 0), d, 3'(i), (i % 3 != 0) ? "R7" : "R8");
    end

    // R9: reset in mid-stream
    step(1'b0, 1'b1, 16'hABCD, 3'b110, "R1 R2 R3");
    step(1'b1, 1'b1, 16'h1234, 3'b001, "R9");
    step(1'b0, 1'b0, 16'h1234, 3'b001, "R9");
    step(1'b0, 1'b1, 16'h1234, 3'b100, "R1 R2 R3");
    step(1'b0, 1'b0, 16'h0000, 3'b000, "R8");
    @(negedge clk);
    compare();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule